// File: doc/BRIEF.md
# Iterative Single-Bit Right Shifter

This block performs a logical right shift of a data word by a variable amount, one bit position per clock. A loadable 5-bit down-counter holds the shift amount. After a start pulse the counter takes its value from a constant field. If that constant is zero, the counter takes its value from the low bits of a count register operand. The data register then loads the operand to be shifted. The shifter steps once per clock, filling zeros at the top, until the counter reaches zero. The result is then written to the output register and a done pulse is raised.

The caller holds all three operands stable from the start pulse until done. The constant field is sampled on the edge that accepts start. The count register operand is sampled one edge later, and the data operand one edge after that. A start pulse is accepted only while the block is idle.

Top module: `iter_shifter`

## Requirements
- R1: After reset, done is low and result is all zeros.
- R2: When the constant field is nonzero, the shift amount n equals the constant field, and the count register operand has no effect.
- R3: When the constant field is zero, the shift amount n equals the count register operand.
- R4: The result equals the data operand shifted right by n positions, with zeros entering at the most significant bit. Each shift clock moves the data one position and lowers the count by one.
- R5: Done rises on the (n+5)th rising edge, counting the edge that samples start as the first.
- R6: When both count sources are zero, no shift clocks occur, the result equals the data operand, and done rises on the 5th edge.
- R7: Done is high for exactly one cycle. The result holds its value until the next done.
- R8: A start pulse that arrives while an operation is in progress is ignored: it changes neither the latency nor the result, and it produces no extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| imm_cnt | input | CNT_W | Constant shift-count field |
| reg_cnt | input | CNT_W | Low bits of the count register operand |
| data_in | input | DATA_W | Value to be shifted |
| result | output | DATA_W | Shifted value, registered at write-back |
| done | output | 1 | One-cycle pulse when result is valid |

## Verification
The bench aims first at the count-source fallback. An immediate of zero paired with a nonzero register count must shift by the register count. A design that skipped the fallback would return the input unshifted, four cycles after start. A nonzero immediate paired with a different register count catches a design that always reads the register. Both counts zero, and the maximum count of 31, test the loop boundaries. An off-by-one loop exit shows up as a wrong latency and a result shifted one place too far or too short. A start injected mid-operation catches a sequencer that restarts, which would stretch the latency or raise a second done.

// File: rtl/iter_shifter_pkg.sv
package iter_shifter_pkg;
   typedef enum logic [2:0] {
      SH_IDLE = 3'd0,
      SH_FIX  = 3'd1,
      SH_LOAD = 3'd2,
      SH_STEP = 3'd3,
      SH_WB   = 3'd4
   } sh_state_e;
endpackage

// File: rtl/shr_count_unit.sv
module shr_count_unit #(
   parameter int CNT_W     = 5,
   parameter bit ZFLAG_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (dec) cnt <= cnt - ONE;
   end

   generate
      if (ZFLAG_REG) begin : g_zreg
         logic zero_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   zero_q <= 1'b1;
            else if (ld)  zero_q <= (ld_val == '0);
            else if (dec) zero_q <= (cnt == ONE);
         end
         assign zero = zero_q;
      end else begin : g_zcomb
         assign zero = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/shr_data_reg.sv
module shr_data_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              step,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= {1'b0, q[DATA_W-1:1]};
   end
endmodule

// File: rtl/shr_seq.sv
module shr_seq
   import iter_shifter_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      cnt_zero,
   output sh_state_e state,
   output logic      cnt_ld,
   output logic      cnt_from_reg,
   output logic      cnt_dec,
   output logic      data_ld,
   output logic      data_step,
   output logic      wb
);
   sh_state_e nxt;

   always_comb begin
      nxt          = state;
      cnt_ld       = 1'b0;
      cnt_from_reg = 1'b0;
      cnt_dec      = 1'b0;
      data_ld      = 1'b0;
      data_step    = 1'b0;
      wb           = 1'b0;
      unique case (state)
         SH_IDLE: if (start) begin
            cnt_ld = 1'b1;
            nxt    = SH_FIX;
         end
         SH_FIX: begin
            if (cnt_zero) begin
               cnt_ld       = 1'b1;
               cnt_from_reg = 1'b1;
            end
            nxt = SH_LOAD;
         end
         SH_LOAD: begin
            data_ld = 1'b1;
            nxt     = SH_STEP;
         end
         SH_STEP: begin
            if (!cnt_zero) begin
               cnt_dec   = 1'b1;
               data_step = 1'b1;
            end else begin
               nxt = SH_WB;
            end
         end
         SH_WB: begin
            wb  = 1'b1;
            nxt = SH_IDLE;
         end
         default: nxt = SH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= SH_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/iter_shifter.sv
module iter_shifter
   import iter_shifter_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = $clog2(DATA_W),
   parameter bit ZFLAG_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  imm_cnt,
   input  logic [CNT_W-1:0]  reg_cnt,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] result,
   output logic              done
);
   localparam int SPAN = 1 << CNT_W;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("iter_shifter: DATA_W must be at least 2");
      end
      if (SPAN != DATA_W) begin : g_bad_cnt
         $error("iter_shifter: CNT_W must equal clog2(DATA_W), DATA_W a power of two");
      end
   endgenerate

   sh_state_e         state;
   logic              cnt_ld, cnt_from_reg, cnt_dec, data_ld, data_step, wb;
   logic              cnt_zero;
   logic [CNT_W-1:0]  cnt_q, cnt_src;
   logic [DATA_W-1:0] data_q;

   assign cnt_src = cnt_from_reg ? reg_cnt : imm_cnt;

   shr_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cnt_zero     (cnt_zero),
      .state        (state),
      .cnt_ld       (cnt_ld),
      .cnt_from_reg (cnt_from_reg),
      .cnt_dec      (cnt_dec),
      .data_ld      (data_ld),
      .data_step    (data_step),
      .wb           (wb)
   );

   shr_count_unit #(.CNT_W(CNT_W), .ZFLAG_REG(ZFLAG_REG)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (cnt_ld),
      .ld_val (cnt_src),
      .dec    (cnt_dec),
      .cnt    (cnt_q),
      .zero   (cnt_zero)
   );

   shr_data_reg #(.DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (data_ld),
      .load_val (data_in),
      .step     (data_step),
      .q        (data_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= wb;
         if (wb) result <= data_q;
      end
   end
endmodule

// File: rtl/iter_shifter_chk.sv
module iter_shifter_chk
   import iter_shifter_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input sh_state_e         st,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] data
);
   a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SH_STEP && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   a_r4_shift_one: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SH_STEP && cnt != '0) |=> (data == {1'b0, $past(data[DATA_W-1:1])}));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SH_WB) |=> $stable(result));

   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (st != SH_IDLE) |=> (st != SH_FIX));

   a_r5_step_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SH_STEP && cnt == '0) |=> (st == SH_WB));
endmodule

bind iter_shifter iter_shifter_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .done   (done),
   .result (result),
   .st     (state),
   .cnt    (cnt_q),
   .data   (data_q)
);

// File: tb/iter_shifter_test.sv
module iter_shifter_test;
   localparam int DW = 32;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] imm_cnt = '0;
   logic [CW-1:0] reg_cnt = '0;
   logic [DW-1:0] data_in = '0;
   logic [DW-1:0] result;
   logic          done;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   iter_shifter uut (
      .clk(clk), .rst_n(rst_n), .start(start), .imm_cnt(imm_cnt),
      .reg_cnt(reg_cnt), .data_in(data_in), .result(result), .done(done)
   );

   function automatic int exp_n(input logic [CW-1:0] k, input logic [CW-1:0] r);
      return (k != '0) ? int'(k) : int'(r);
   endfunction

   function automatic logic [DW-1:0] exp_res(input logic [DW-1:0] d, input int n);
      return d >> n;
   endfunction

   task automatic check(input string req, input string what, input logic [DW-1:0] got,
                        input logic [DW-1:0] expv);
      total++;
      if (got !== expv) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, expv);
      end
   endtask

   task automatic run_op(input logic [CW-1:0] k, input logic [CW-1:0] r,
                         input logic [DW-1:0] d, input bit poke, input string req);
      int n;
      int lat;
      logic [DW-1:0] held;
      n = exp_n(k, r);
      @(negedge clk);
      imm_cnt = k; reg_cnt = r; data_in = d; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 100) begin
         @(negedge clk);
         lat++;
         if (poke && lat == 3) start = 1'b1;
         else start = 1'b0;
      end
      start = 1'b0;
      check(req, "done seen", {31'd0, done}, 32'd1);
      check({req, " R4"}, "result", result, exp_res(d, n));
      check({req, " R5"}, "latency", lat, n + 5);
      held = result;
      @(negedge clk);
      check("R7", "done drops", {31'd0, done}, 32'd0);
      @(negedge clk);
      check("R7", "result held", result, held);
   endtask

   initial begin
      #(4 * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] seed_dummy;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      check("R1", "done after reset", {31'd0, done}, 32'd0);
      check("R1", "result after reset", result, 32'd0);
      rst_n = 1'b1;

      run_op(5'd3, 5'd17, 32'hF000_000F, 1'b0, "R2");
      run_op(5'd31, 5'd1, 32'h8000_0000, 1'b0, "R2");
      run_op(5'd0, 5'd9, 32'hDEAD_BEEF, 1'b0, "R3");
      run_op(5'd0, 5'd31, 32'hFFFF_FFFF, 1'b0, "R3");
      run_op(5'd0, 5'd0, 32'h1234_5678, 1'b0, "R6");
      run_op(5'd1, 5'd0, 32'h0000_0001, 1'b0, "R4");
      run_op(5'd6, 5'd2, 32'hA5A5_5A5A, 1'b1, "R8");
      run_op(5'd0, 5'd4, 32'h0F0F_0F0F, 1'b1, "R8");

      for (int i = 0; i < 40; i++) begin
         logic [CW-1:0] k;
         logic [CW-1:0] r;
         logic [DW-1:0] d;
         k = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
         r = 5'($urandom);
         d = $urandom;
         run_op(k, r, d, 1'($urandom % 5 == 0), (k == 0) ? "R3" : "R2");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule